// File: doc/BRIEF.md
# Cache Range Maintenance Engine

This block is the maintenance side of a physically tagged second-level cache. A requester issues commands on a single command port. A per-line command names one address and cleans it, drops it, or cleans and then drops it. A range command takes two writes. The first write sets the lower address. The second write gives the upper address and starts the work. The engine then visits every line from the lower line to the upper line, including the upper line. Each visit takes one cycle. A dirty line that has to be cleaned costs one extra cycle on a write-back port.

While the engine works, `busy` stalls the requester. Any command presented during that time receives an immediate retry and is dropped. A range whose two addresses fall in different pages is refused and raises a sticky error flag. A write-through override makes every line clean: cleaning then writes nothing back. A small control word holds a cache-enable bit and a prefetch-disable bit. The enable bit can change only while both first-level caches are switched off.

Lines enter the tag/state array through a simple install port. This port stands in for the memory system.

Top module: `cache_maint_engine`

## Requirements
- R1: A line is 32 bytes. A range visits every line whose first byte address lies between the lower and the upper address, both ends included. Every write-back address is the line's first byte address.
- R2: Command codes are: 0 clean line, 1 invalidate line, 2 clean-and-invalidate line, 3 set range start, 4 clean range (upper address), 5 invalidate range (upper address). Codes 6 and 7 do nothing. Code 3 only stores the address and never sets `busy`.
- R3: `busy` rises in the cycle after an accepted command that has work to do. It stays high for one cycle per visited line, plus the cycles each write-back spends with `wb_valid` high.
- R4: If the lower and upper addresses of a range differ in any bit above the 4 KiB page offset, `err_flag` is set and the range is not run. `err_flag` holds until `err_clr` is asserted. If a set and a clear happen in the same cycle, the set wins.
- R5: Clean writes back a dirty line and marks it clean. Invalidate drops the line with no write-back. Clean-and-invalidate writes back a dirty line and then drops it. A line that misses in the array is left alone.
- R6: The write-back port uses valid/ready. Once raised, `wb_valid` and `wb_addr` hold steady until `wb_ready` is seen high. Each dirty line that is cleaned produces exactly one transfer.
- R7: `ctrl_q` reports the enable bit at bit 22 and the prefetch-disable bit at bit 24. Every other bit reads 0. Reset clears both bits.
- R8: A control write updates bit 24 unconditionally. It updates bit 22 only when `l1_icache_on` and `l1_dcache_on` are both low. Otherwise bit 22 keeps its value.
- R9: While `wt_override` is high, installs are stored clean and no write-back is issued. A clean therefore leaves the line unchanged, and clean-and-invalidate simply drops the line.
- R10: A command presented while `busy` is high sees `cmd_retry` high in the same cycle and has no effect.
- R11: An install is ignored while `busy` is high or while the enable bit is 0.
- R12: A range whose upper line lies below its lower line does no work, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (R2) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_retry | output | 1 | Command refused, engine busy |
| busy | output | 1 | Requester stall |
| err_flag | output | 1 | Sticky page-crossing error |
| err_clr | input | 1 | Clears `err_flag` |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_q | output | 32 | Control word readback |
| l1_icache_on | input | 1 | First-level instruction cache enabled |
| l1_dcache_on | input | 1 | First-level data cache enabled |
| wt_override | input | 1 | Force write-through behaviour |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | ADDR_W | Install address |
| fill_dirty | input | 1 | Installed line is dirty |
| wb_valid | output | 1 | Write-back request |
| wb_ready | input | 1 | Write-back accepted |
| wb_addr | output | ADDR_W | Write-back line address |

## Verification
The bench builds the engine with a 16-bit address and an 8-set array. A full page is 128 lines, so ranges wrap over the set index, and lines with different tags share a set. This makes tag misses, page crossings and the refused-install cases easy to reach. In one long range, `wb_ready` toggles every cycle so that back-pressure holds write-backs. Another range runs with `wb_ready` held high so that the stall length can be counted exactly.

// File: rtl/cme_pkg.sv
package cme_pkg;
  localparam int EN_BIT = 22;
  localparam int PF_BIT = 24;

  typedef enum logic [2:0] {
    OP_LINE_CLEAN = 3'd0,
    OP_LINE_INV   = 3'd1,
    OP_LINE_CINV  = 3'd2,
    OP_RANGE_LO   = 3'd3,
    OP_RANGE_CLN  = 3'd4,
    OP_RANGE_INV  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    MODE_CLEAN = 2'd0,
    MODE_INV   = 2'd1,
    MODE_CINV  = 2'd2
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WB   = 2'd2
  } state_e;
endpackage

// File: rtl/cme_ctrl_reg.sv
module cme_ctrl_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  input  logic        l1_i_on,
  input  logic        l1_d_on,
  output logic [31:0] q,
  output logic        en
);
  import cme_pkg::*;
  logic pf_q, en_q;
  logic unused_wbits;
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      en_q <= 1'b0;
    end else if (we) begin
      pf_q <= wdata[PF_BIT];
      if (!l1_i_on && !l1_d_on) en_q <= wdata[EN_BIT];
    end
  end

  always_comb begin
    q = '0;
    q[PF_BIT] = pf_q;
    q[EN_BIT] = en_q;
  end
  assign en = en_q;
endmodule

// File: rtl/cme_cmd_decode.sv
module cme_cmd_decode #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 5,
  parameter int PG_W   = 12,
  localparam int LN_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              busy,
  input  logic              err_clr,
  output logic              err,
  output logic              launch,
  output logic [LN_W-1:0]   first_ln,
  output logic [LN_W-1:0]   last_ln,
  output cme_pkg::mode_e    mode
);
  import cme_pkg::*;
  logic [ADDR_W-1:0] lo_q;
  logic              accept, page_bad, backward, err_set;
  logic [LN_W-1:0]   addr_ln;
  logic              unused_lo;

  assign accept   = cmd_valid && !busy;
  assign addr_ln  = cmd_addr[ADDR_W-1:OFF_W];
  assign page_bad = lo_q[ADDR_W-1:PG_W] != cmd_addr[ADDR_W-1:PG_W];
  assign backward = addr_ln < lo_q[ADDR_W-1:OFF_W];
  assign unused_lo = ^{lo_q[OFF_W-1:0], cmd_addr[OFF_W-1:0]};

  always_comb begin
    launch   = 1'b0;
    err_set  = 1'b0;
    first_ln = addr_ln;
    last_ln  = addr_ln;
    mode     = MODE_CLEAN;
    if (accept) begin
      case (cmd_op)
        OP_LINE_CLEAN: launch = 1'b1;
        OP_LINE_INV:   begin launch = 1'b1; mode = MODE_INV; end
        OP_LINE_CINV:  begin launch = 1'b1; mode = MODE_CINV; end
        OP_RANGE_CLN, OP_RANGE_INV: begin
          first_ln = lo_q[ADDR_W-1:OFF_W];
          mode     = (cmd_op == OP_RANGE_INV) ? MODE_INV : MODE_CLEAN;
          if (page_bad) err_set = 1'b1;
          else launch = !backward;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      err  <= 1'b0;
    end else begin
      if (accept && cmd_op == OP_RANGE_LO) lo_q <= cmd_addr;
      if (err_set) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end
endmodule

// File: rtl/cme_tag_array.sv
module cme_tag_array #(
  parameter int SETS  = 64,
  parameter int TAG_W = 9,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_dirty,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_drop,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag
);
  logic [SETS-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (upd_en) begin
      dirty_q[upd_idx] <= 1'b0;
      if (upd_drop) valid_q[upd_idx] <= 1'b0;
    end else if (fill_en) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= fill_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !upd_en) tag_q[fill_idx] <= fill_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cme_walker.sv
module cme_walker #(
  parameter int LN_W  = 15,
  parameter int IDX_W = 6,
  parameter int OFF_W = 5,
  localparam int TAG_W = LN_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [LN_W-1:0]    first_ln,
  input  logic [LN_W-1:0]    last_ln,
  input  cme_pkg::mode_e     mode,
  input  logic               wt,
  input  logic               rd_valid,
  input  logic               rd_dirty,
  input  logic [TAG_W-1:0]   rd_tag,
  input  logic               wb_ready,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               upd_en,
  output logic               upd_drop,
  output logic               busy,
  output logic               wb_valid,
  output logic [LN_W+OFF_W-1:0] wb_addr
);
  import cme_pkg::*;
  state_e          st_q;
  mode_e           mode_q;
  logic [LN_W-1:0] cur_q, last_q;
  logic            hit, need_wb, step;

  assign rd_idx  = cur_q[IDX_W-1:0];
  assign hit     = rd_valid && (rd_tag == cur_q[LN_W-1:IDX_W]);
  assign need_wb = hit && rd_dirty && (mode_q != MODE_INV) && !wt;

  always_comb begin
    step     = 1'b0;
    upd_en   = 1'b0;
    upd_drop = 1'b0;
    case (st_q)
      ST_WALK: if (!need_wb) begin
        step     = 1'b1;
        upd_en   = hit && (mode_q != MODE_CLEAN);
        upd_drop = 1'b1;
      end
      ST_WB: if (wb_ready) begin
        step     = 1'b1;
        upd_en   = 1'b1;
        upd_drop = (mode_q == MODE_CINV);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_CLEAN;
      cur_q  <= '0;
      last_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_WALK;
          cur_q  <= first_ln;
          last_q <= last_ln;
          mode_q <= mode;
        end
        ST_WALK: if (need_wb) st_q <= ST_WB;
        default: ;
      endcase
      if (step) begin
        if (cur_q == last_q) st_q <= ST_IDLE;
        else begin
          st_q  <= ST_WALK;
          cur_q <= cur_q + 1'b1;
        end
      end
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign wb_valid = (st_q == ST_WB);
  assign wb_addr  = {cur_q, {OFF_W{1'b0}}};
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
  parameter int ADDR_W     = 20,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int SETS       = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_retry,
  output logic              busy,
  output logic              err_flag,
  input  logic              err_clr,
  input  logic              ctrl_we,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_q,
  input  logic              l1_icache_on,
  input  logic              l1_dcache_on,
  input  logic              wt_override,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_dirty,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr
);
  import cme_pkg::*;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int LN_W  = ADDR_W - OFF_W;
  localparam int TAG_W = LN_W - IDX_W;

  logic             cache_en, launch, upd_en, upd_drop;
  logic [LN_W-1:0]  first_ln, last_ln;
  mode_e            mode;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid, rd_dirty;
  logic [TAG_W-1:0] rd_tag;
  logic             unused_fill;

  assign unused_fill = ^fill_addr[OFF_W-1:0];
  assign cmd_retry   = cmd_valid && busy;

  cme_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata),
    .l1_i_on(l1_icache_on), .l1_d_on(l1_dcache_on), .q(ctrl_q), .en(cache_en)
  );

  cme_cmd_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .PG_W(PG_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .busy(busy), .err_clr(err_clr), .err(err_flag),
    .launch(launch), .first_ln(first_ln), .last_ln(last_ln), .mode(mode)
  );

  cme_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_valid && !busy && cache_en),
    .fill_idx(fill_addr[OFF_W +: IDX_W]),
    .fill_tag(fill_addr[ADDR_W-1:OFF_W+IDX_W]),
    .fill_dirty(fill_dirty && !wt_override),
    .upd_en(upd_en), .upd_idx(rd_idx), .upd_drop(upd_drop),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag)
  );

  cme_walker #(.LN_W(LN_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .first_ln(first_ln),
    .last_ln(last_ln), .mode(mode), .wt(wt_override), .rd_valid(rd_valid),
    .rd_dirty(rd_dirty), .rd_tag(rd_tag), .wb_ready(wb_ready), .rd_idx(rd_idx),
    .upd_en(upd_en), .upd_drop(upd_drop), .busy(busy), .wb_valid(wb_valid),
    .wb_addr(wb_addr)
  );
endmodule

module cme_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              cmd_retry,
  input logic              busy,
  input logic              err_flag,
  input logic              err_clr,
  input logic              ctrl_we,
  input logic [31:0]       ctrl_q,
  input logic              l1_icache_on,
  input logic              l1_dcache_on,
  input logic              wt_override,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [ADDR_W-1:0] wb_addr
);
  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  // R3
  wb_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> busy);
  // R10
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy |-> cmd_retry);
  // R10
  no_retry_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_retry);
  // R8
  en_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we && (l1_icache_on || l1_dcache_on) |=> ctrl_q[22] == $past(ctrl_q[22]));
  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  // R9
  wt_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wt_override && !wb_valid |=> !wb_valid);
  // R2
  start_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && cmd_op == 3'd3 |=> !busy);
endmodule

bind cache_maint_engine cme_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_retry(cmd_retry), .busy(busy), .err_flag(err_flag), .err_clr(err_clr),
  .ctrl_we(ctrl_we), .ctrl_q(ctrl_q), .l1_icache_on(l1_icache_on),
  .l1_dcache_on(l1_dcache_on), .wt_override(wt_override), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_addr(wb_addr)
);

// File: tb/test_cache_maint_engine.sv
`timescale 1ns/1ps
module test_cache_maint_engine;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [AW-1:0] cmd_addr = 0;
  logic cmd_retry, busy, err_flag, wb_valid;
  logic err_clr = 0, ctrl_we = 0, l1_i = 0, l1_d = 0, wt = 0;
  logic [31:0] ctrl_wdata = 0, ctrl_q;
  logic fill_valid = 0, fill_dirty = 0, wb_ready = 1;
  logic [AW-1:0] fill_addr = 0, wb_addr;
  int checks = 0, fails = 0, wb_cnt = 0, busy_cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cache_maint_engine #(.ADDR_W(AW), .SETS(8)) i_cache_maint_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_retry(cmd_retry), .busy(busy), .err_flag(err_flag),
    .err_clr(err_clr), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .l1_icache_on(l1_i), .l1_dcache_on(l1_d), .wt_override(wt),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit mv[8], md[8]; int mt[8];
  bit m_busy, m_wb, m_err, m_en, m_pf; int m_cur, m_last, m_mode, m_lo;

  always @(posedge clk) begin
    bit b; int idx; bit hit;
    b = m_busy;
    if (!rst_n) begin
      foreach (mv[i]) begin mv[i] = 0; md[i] = 0; end
      m_busy = 0; m_wb = 0; m_err = 0; m_en = 0; m_pf = 0; m_lo = 0;
      m_cur = 0; m_last = 0; m_mode = 0;
    end else begin
      if (ctrl_we) begin
        m_pf = ctrl_wdata[24];
        if (!l1_i && !l1_d) m_en = ctrl_wdata[22];
      end
      if (err_clr) m_err = 0;
      if (fill_valid && !b && m_en) begin
        idx = (fill_addr >> 5) % 8;
        mv[idx] = 1; mt[idx] = fill_addr >> 8; md[idx] = fill_dirty && !wt;
      end
      if (b) begin
        idx = m_cur % 8;
        hit = mv[idx] && mt[idx] == (m_cur >> 3);
        if (m_wb) begin
          if (wb_ready) begin
            md[idx] = 0;
            if (m_mode == 2) mv[idx] = 0;
            m_wb = 0;
            if (m_cur == m_last) m_busy = 0; else m_cur++;
          end
        end else if (hit && md[idx] && m_mode != 1 && !wt) m_wb = 1;
        else begin
          if (hit && m_mode != 0) begin mv[idx] = 0; md[idx] = 0; end
          if (m_cur == m_last) m_busy = 0; else m_cur++;
        end
      end else if (cmd_valid) begin
        if (cmd_op <= 2) begin
          m_cur = cmd_addr >> 5; m_last = m_cur; m_mode = cmd_op; m_busy = 1;
        end else if (cmd_op == 3) m_lo = cmd_addr;
        else if (cmd_op == 4 || cmd_op == 5) begin
          if ((m_lo >> 12) != (cmd_addr >> 12)) m_err = 1;
          else if ((cmd_addr >> 5) >= (m_lo >> 5)) begin
            m_cur = m_lo >> 5; m_last = cmd_addr >> 5;
            m_mode = (cmd_op == 5) ? 1 : 0; m_busy = 1;
          end
        end
      end
    end
    #5;
    if (rst_n) begin
      check("R3 busy", busy, m_busy);
      check("R6 wb_valid", wb_valid, m_wb);
      if (m_wb) check("R1 wb_addr", wb_addr, m_cur << 5);
      check("R10 retry", cmd_retry, cmd_valid && m_busy);
      check("R4 err", err_flag, m_err);
      check("R8 ctrl_q", ctrl_q, (m_pf << 24) | (m_en << 22));
      if (busy) busy_cyc++;
    end
    #10;
    if (wb_valid && wb_ready) wb_cnt++;
  end

  task automatic cmd(int op, int addr);
    @(negedge clk); cmd_valid = 1; cmd_op = op[2:0]; cmd_addr = addr[AW-1:0];
    @(negedge clk); cmd_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic rng(int op, int lo, int hi);
    cmd(3, lo); cmd(op, hi);
  endtask
  task automatic fill(int addr, bit d);
    @(negedge clk); fill_valid = 1; fill_addr = addr[AW-1:0]; fill_dirty = d;
    @(negedge clk); fill_valid = 0;
  endtask
  task automatic wctrl(int v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset ctrl", ctrl_q, 0);
    check("R3 reset busy", busy, 0);
    check("R4 reset err", err_flag, 0);
    wctrl(32'h0140_0000);
    check("R7 ctrl bits", ctrl_q, 32'h0140_0000);
    l1_d = 1; wctrl(0); l1_d = 0;
    check("R8 enable locked", ctrl_q, 32'h0040_0000);
    for (int i = 0; i < 8; i++) fill(32'h1000 + 32 * i, (i % 2) == 0);
    // R6: back-pressure on the write-back port
    cmd(3, 32'h1000);
    check("R2 start alone idle", busy, 0);
    fork
      begin
        w0 = wb_cnt; cmd(4, 32'h10E0);
      end
      begin
        repeat (40) begin @(negedge clk); wb_ready = ~wb_ready; end
        wb_ready = 1;
      end
    join
    check("R5 range clean dirty evens", wb_cnt - w0, 4);
    w0 = wb_cnt; rng(4, 32'h1000, 32'h10E0);
    check("R5 second clean none", wb_cnt - w0, 0);
    for (int i = 0; i < 4; i++) fill(32'h1000 + 32 * i, 1);
    w0 = wb_cnt; rng(4, 32'h1020, 32'h1040);
    check("R1 inclusive end", wb_cnt - w0, 2);
    w0 = wb_cnt; cmd(2, 32'h1000);
    check("R5 clean-inv dirty", wb_cnt - w0, 1);
    w0 = wb_cnt; cmd(0, 32'h1000);
    check("R5 dropped after clean-inv", wb_cnt - w0, 0);
    w0 = wb_cnt; cmd(1, 32'h1060); cmd(0, 32'h1060);
    check("R5 invalidate no wb", wb_cnt - w0, 0);
    // R4 page crossing
    rng(4, 32'h1FE0, 32'h2000);
    check("R4 err set", err_flag, 1);
    repeat (3) @(negedge clk);
    check("R4 err sticky", err_flag, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    check("R4 err cleared", err_flag, 0);
    // R12 backwards range
    busy_cyc = 0; rng(4, 32'h1040, 32'h1020);
    check("R12 no busy", busy_cyc, 0);
    // R9 write-through override
    fill(32'h1080, 1); wt = 1;
    w0 = wb_cnt; rng(4, 32'h1080, 32'h1080);
    check("R9 clean under wt", wb_cnt - w0, 0);
    wt = 0; w0 = wb_cnt; cmd(0, 32'h1080);
    check("R9 line kept dirty", wb_cnt - w0, 1);
    wt = 1; fill(32'h10A0, 1); wt = 0;
    w0 = wb_cnt; cmd(0, 32'h10A0);
    check("R9 fill stored clean", wb_cnt - w0, 0);
    fill(32'h10C0, 1); wt = 1; cmd(2, 32'h10C0); wt = 0;
    w0 = wb_cnt; cmd(0, 32'h10C0);
    check("R9 clean-inv drops", wb_cnt - w0, 0);
    // R3 stall length, R10 retry, R11 fill while busy
    for (int i = 0; i < 8; i++) fill(32'h1000 + 32 * i, 1);
    cmd(3, 32'h1000);
    busy_cyc = 0; w0 = wb_cnt;
    @(negedge clk); cmd_valid = 1; cmd_op = 4; cmd_addr = 16'h10E0;
    @(negedge clk); cmd_op = 0; cmd_addr = 16'h1100;
    fill_valid = 1; fill_addr = 16'h1100; fill_dirty = 1;
    #1 check("R10 retry while busy", cmd_retry, 1);
    @(negedge clk); cmd_valid = 0; fill_valid = 0;
    while (busy) @(negedge clk);
    check("R3 stall cycles", busy_cyc, 16);
    check("R6 one wb per dirty", wb_cnt - w0, 8);
    w0 = wb_cnt; cmd(2, 32'h1100);
    check("R11 fill ignored busy", wb_cnt - w0, 0);
    // R11 disabled cache
    wctrl(0);
    check("R8 enable cleared", ctrl_q, 0);
    fill(32'h2040, 1); wctrl(32'h0040_0000);
    w0 = wb_cnt; cmd(0, 32'h2040);
    check("R11 fill ignored disabled", wb_cnt - w0, 0);
    fill(32'h2040, 1); w0 = wb_cnt; cmd(0, 32'h2040);
    check("R11 fill taken enabled", wb_cnt - w0, 1);
    cmd(7, 32'h2040);
    check("R2 reserved code idle", busy, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule